// File: doc/BRIEF.md
# SAR ADC Conversion-Start and Readout Sequencer

This block sits between a periodic sample strobe in the system clock domain and a successive-approximation converter that runs on its own internal conversion clock. When a strobe arrives and the block is idle, it drives a short active-low start pulse. The converter holds its sample on that falling edge. The pulse returns high long before the conversion can end. The block then waits for the converter's end-of-conversion signal, which is asynchronous and has jitter. That signal is synchronised and edge-detected; the block never counts a fixed conversion time.

After a configurable quiet gap, the block reads the result over a burst serial link. Chip select goes low, a fixed number of serial clock pulses are issued, and the data bits are captured most significant bit first. The word is then presented with a one-cycle valid pulse. The serial clock and chip select stay static outside the burst. Strobes that arrive too early are dropped and recorded as an overrun. A missing end-of-conversion is caught by a timeout, which returns the block to idle and raises an error.

Top module: `adc_seq_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, conv_start_n_o and cs_n_o are 1, and sclk_o, result_valid_o, overrun_o and error_o are 0.
- R2: A sample strobe sampled high while idle drives conv_start_n_o low from the next clock edge for exactly START_LOW_CYC cycles. Throughout that time cs_n_o stays 1 and sclk_o stays 0.
- R3: Readout waits for a rising edge of eoc_i (active high) after two synchroniser stages. cs_n_o falls QUIET_CYC+2 clock edges after the first edge that samples eoc_i high. cs_n_o stays high for as long as eoc_i stays low.
- R4: A readout produces RES_W pulses on sclk_o. The clock is low for SCLK_HALF cycles after cs_n_o falls, and each high and low phase then lasts SCLK_HALF cycles. sdi_i is sampled at the edge that raises sclk_o. The first bit sampled is the most significant bit of result_o.
- R5: At the edge that ends the last low phase, cs_n_o returns to 1, and result_valid_o is 1 for exactly one cycle while result_o holds the word.
- R6: A strobe sampled while a conversion or readout is in progress starts nothing and sets overrun_o. overrun_o stays 1 until reset.
- R7: If no end-of-conversion edge is seen within TIMEOUT_CYC cycles after conv_start_n_o returns high, error_o is set and the block goes idle without any readout. A later strobe is accepted normally.
- R8: For QUIET_CYC+1 edges after the valid pulse, strobes are ignored and set overrun_o. After that window, a strobe starts a new conversion.
- R9: error_o stays 1 until reset, including across later successful conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Asynchronous active-high reset |
| sample_strobe_i | input | 1 | One-cycle request to take a sample |
| eoc_i | input | 1 | Asynchronous end-of-conversion from the converter, active high |
| sdi_i | input | 1 | Serial data from the converter |
| conv_start_n_o | output | 1 | Active-low conversion-start pulse |
| cs_n_o | output | 1 | Active-low chip select for readout |
| sclk_o | output | 1 | Burst serial clock, idle low |
| result_o | output | RES_W | Last word read out |
| result_valid_o | output | 1 | One-cycle pulse when result_o is updated |
| overrun_o | output | 1 | Sticky flag for a dropped strobe |
| error_o | output | 1 | Sticky flag for an end-of-conversion timeout |

## Verification
Conversions run with end-of-conversion arriving near the 1.36 µs minimum and also much later, with result words that are alternating, all ones and a single low bit. These patterns show whether the bit order is right and whether the synchroniser delay has been counted correctly. Strobes placed during the conversion wait and inside the hold-off after the valid pulse exercise the overrun path separately from normal acceptance. A conversion with no end-of-conversion, followed by a good one, separates the timeout abort from the sticky error flag.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_START,
        SQ_CONV,
        SQ_GAP,
        SQ_READ,
        SQ_HOLD
    } seq_state_e;

endpackage

// File: rtl/adc_eoc_sync.sv
module adc_eoc_sync (
    input  logic clk_i,
    input  logic rst_i,
    input  logic eoc_async_i,
    output logic eoc_rise_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.s1   = eoc_async_i;
        r_d.s2   = r_q.s1;
        r_d.prev = r_q.s2;
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) r_q <= '0;
        else       r_q <= r_d;
    end

    assign eoc_rise_o = r_q.s2 & ~r_q.prev;

    // R3: a detected edge lasts a single cycle
    p_rise_single_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        eoc_rise_o |=> !eoc_rise_o);

endmodule

// File: rtl/adc_spi_rx.sv
module adc_spi_rx #(
    parameter int RES_W     = 14,
    parameter int SCLK_HALF = 3
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             launch_i,
    input  logic             sdi_i,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic             done_o,
    output logic [RES_W-1:0] data_o
);
    localparam int HC_W  = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
    localparam int BIT_W = $clog2(RES_W);

    typedef struct packed {
        logic             cs_n;
        logic             sclk;
        logic             done;
        logic [HC_W-1:0]  hc;
        logic [BIT_W-1:0] bits;
        logic [RES_W-1:0] shift;
        logic [RES_W-1:0] data;
    } spi_t;

    spi_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (launch_i) begin
            s_d.cs_n = 1'b0;
            s_d.sclk = 1'b0;
            s_d.hc   = HC_W'(SCLK_HALF - 1);
            s_d.bits = '0;
        end else if (!s_q.cs_n) begin
            if (s_q.hc == '0) begin
                s_d.hc = HC_W'(SCLK_HALF - 1);
                if (!s_q.sclk) begin
                    s_d.sclk  = 1'b1;
                    s_d.shift = {s_q.shift[RES_W-2:0], sdi_i};
                end else begin
                    s_d.sclk = 1'b0;
                    if (s_q.bits == BIT_W'(RES_W - 1)) begin
                        s_d.cs_n = 1'b1;
                        s_d.done = 1'b1;
                        s_d.data = s_q.shift;
                    end else begin
                        s_d.bits = s_q.bits + 1'b1;
                    end
                end
            end else begin
                s_d.hc = s_q.hc - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            s_q      <= '0;
            s_q.cs_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cs_n_o = s_q.cs_n;
    assign sclk_o = s_q.sclk;
    assign done_o = s_q.done;
    assign data_o = s_q.data;

    // R4: serial clock only toggles inside a chip-select burst
    p_sclk_in_burst_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        sclk_o |-> !cs_n_o);

    // R5: completion leaves the link idle
    p_done_idle_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> (cs_n_o && !sclk_o));

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
    parameter int RES_W         = 14,
    parameter int START_LOW_CYC = 12,
    parameter int QUIET_CYC     = 8,
    parameter int SCLK_HALF     = 3,
    parameter int TIMEOUT_CYC   = 1000
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             sample_strobe_i,
    input  logic             eoc_i,
    input  logic             sdi_i,
    output logic             conv_start_n_o,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic [RES_W-1:0] result_o,
    output logic             result_valid_o,
    output logic             overrun_o,
    output logic             error_o
);
    import adc_seq_pkg::*;

    localparam int MAX_AB = (START_LOW_CYC > QUIET_CYC) ? START_LOW_CYC : QUIET_CYC;
    localparam int MAX_C  = (MAX_AB > TIMEOUT_CYC) ? MAX_AB : TIMEOUT_CYC;
    localparam int CNT_W  = $clog2(MAX_C + 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             conv_n;
        logic             ovr;
        logic             err;
    } seq_t;

    seq_t r_d, r_q;
    logic eoc_rise;
    logic launch;
    logic spi_done;

    adc_eoc_sync i_sync (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .eoc_async_i (eoc_i),
        .eoc_rise_o  (eoc_rise)
    );

    adc_spi_rx #(
        .RES_W     (RES_W),
        .SCLK_HALF (SCLK_HALF)
    ) i_spi (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .launch_i (launch),
        .sdi_i    (sdi_i),
        .cs_n_o   (cs_n_o),
        .sclk_o   (sclk_o),
        .done_o   (spi_done),
        .data_o   (result_o)
    );

    always_comb begin
        r_d    = r_q;
        launch = 1'b0;
        case (r_q.st)
            SQ_IDLE: begin
                if (sample_strobe_i) begin
                    r_d.st     = SQ_START;
                    r_d.conv_n = 1'b0;
                    r_d.cnt    = CNT_W'(START_LOW_CYC - 1);
                end
            end
            SQ_START: begin
                if (r_q.cnt == '0) begin
                    r_d.conv_n = 1'b1;
                    r_d.st     = SQ_CONV;
                    r_d.cnt    = CNT_W'(TIMEOUT_CYC - 1);
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            SQ_CONV: begin
                if (eoc_rise) begin
                    r_d.st  = SQ_GAP;
                    r_d.cnt = CNT_W'(QUIET_CYC - 1);
                end else if (r_q.cnt == '0) begin
                    r_d.err = 1'b1;
                    r_d.st  = SQ_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            SQ_GAP: begin
                if (r_q.cnt == '0) begin
                    launch = 1'b1;
                    r_d.st = SQ_READ;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            SQ_READ: begin
                if (spi_done) begin
                    r_d.st  = SQ_HOLD;
                    r_d.cnt = CNT_W'(QUIET_CYC - 1);
                end
            end
            SQ_HOLD: begin
                if (r_q.cnt == '0) r_d.st = SQ_IDLE;
                else               r_d.cnt = r_q.cnt - 1'b1;
            end
            default: r_d.st = SQ_IDLE;
        endcase
        if (sample_strobe_i && (r_q.st != SQ_IDLE)) r_d.ovr = 1'b1;
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            r_q        <= '0;
            r_q.st     <= SQ_IDLE;
            r_q.conv_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign conv_start_n_o = r_q.conv_n;
    assign result_valid_o = spi_done;
    assign overrun_o      = r_q.ovr;
    assign error_o        = r_q.err;

    // R2: serial lines are static while the start pulse is low
    p_quiet_start_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !conv_start_n_o |-> (cs_n_o && !sclk_o));

    // R2: every falling start edge follows an accepted strobe
    p_start_on_strobe_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(conv_start_n_o) |-> $past(sample_strobe_i));

    // R5: valid is a single-cycle pulse
    p_valid_pulse_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        result_valid_o |=> !result_valid_o);

    // R6: overrun is sticky
    p_ovr_sticky_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        overrun_o |=> overrun_o);

    // R9: error is sticky
    p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        error_o |=> error_o);

endmodule

// File: tb/test_adc_seq_top.sv
module test_adc_seq_top;
    localparam int W  = 14;
    localparam int SL = 12;
    localparam int QC = 8;
    localparam int HF = 3;
    localparam int TO = 1000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic strobe = 1'b0;
    logic eoc = 1'b0;
    logic sdi = 1'b0;
    logic conv_n, cs_n, sclk, valid, ovr, err;
    logic [W-1:0] result;

    always #2.5 clk = ~clk;

    adc_seq_top #(
        .RES_W(W), .START_LOW_CYC(SL), .QUIET_CYC(QC),
        .SCLK_HALF(HF), .TIMEOUT_CYC(TO)
    ) i_adc_seq_top (
        .clk_i(clk), .rst_i(rst), .sample_strobe_i(strobe), .eoc_i(eoc),
        .sdi_i(sdi), .conv_start_n_o(conv_n), .cs_n_o(cs_n), .sclk_o(sclk),
        .result_o(result), .result_valid_o(valid), .overrun_o(ovr), .error_o(err)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- converter model (serial side) ----------------
    logic [W-1:0] slave_word = '0;
    int  sidx = 0;
    logic prev_cs = 1'b1, prev_sclk = 1'b0;
    always @(negedge clk) begin
        if (prev_cs && !cs_n) begin
            sidx = W - 1;
            sdi  <= slave_word[W-1];
        end else if (!cs_n && prev_sclk && !sclk) begin
            sidx = sidx - 1;
            if (sidx >= 0) sdi <= slave_word[sidx];
        end
        prev_cs   = cs_n;
        prev_sclk = sclk;
    end

    // ---------------- behavioural reference ----------------
    // phases: 0 idle, 1 start low, 2 wait eoc, 3 gap, 4 burst, 5 done, 6 hold-off
    int   ph = 0, tm = 0;
    bit   eh0, eh1, eh2, eh3;
    bit   e_conv_n = 1, e_cs_n = 1, e_sclk = 0, e_valid = 0, e_ovr = 0, e_err = 0;
    logic [W-1:0] m_acc = '0, e_data = '0;

    always @(posedge clk) begin
        if (rst) begin
            ph = 0; tm = 0; eh0 = 0; eh1 = 0; eh2 = 0; eh3 = 0;
            e_conv_n = 1; e_cs_n = 1; e_sclk = 0; e_valid = 0; e_ovr = 0; e_err = 0;
            e_data = '0; m_acc = '0;
        end else begin
            bit st_in, rise;
            st_in = strobe;
            eh3 = eh2; eh2 = eh1; eh1 = eh0; eh0 = eoc;
            rise = eh2 && !eh3;
            e_valid = 0;
            if (st_in && ph != 0) e_ovr = 1;
            case (ph)
                0: if (st_in) begin ph = 1; tm = 0; e_conv_n = 0; end
                1: begin tm++; if (tm == SL) begin e_conv_n = 1; ph = 2; tm = 0; end end
                2: begin
                    if (rise) begin ph = 3; tm = 0; end
                    else begin tm++; if (tm == TO) begin e_err = 1; ph = 0; end end
                end
                3: begin tm++; if (tm == QC) begin e_cs_n = 0; e_sclk = 0; ph = 4; tm = 0; end end
                4: begin
                    tm++;
                    if (tm % HF == 0) begin
                        if (((tm / HF) % 2) == 1) begin
                            e_sclk = 1; m_acc = {m_acc[W-2:0], sdi};
                        end else begin
                            e_sclk = 0;
                            if (tm / HF == 2 * W) begin
                                e_cs_n = 1; e_valid = 1; e_data = m_acc; ph = 5;
                            end
                        end
                    end
                end
                5: begin ph = 6; tm = 0; end
                default: begin tm++; if (tm == QC) ph = 0; end
            endcase
        end
    end

    bit armed = 0;
    always @(negedge clk) begin
        if (armed && !rst) begin
            chk(conv_n == e_conv_n, "R2", "conv_start_n", conv_n, e_conv_n);
            chk(cs_n == e_cs_n,     "R3", "cs_n", cs_n, e_cs_n);
            chk(sclk == e_sclk,     "R4", "sclk", sclk, e_sclk);
            chk(valid == e_valid,   "R5", "valid", valid, e_valid);
            chk(ovr == e_ovr,       "R6", "overrun", ovr, e_ovr);
            chk(err == e_err,       "R7", "error", err, e_err);
            if (valid) begin
                chk(result == slave_word, "R4", "result vs converter word", result, slave_word);
                chk(result == e_data,     "R5", "result vs model", result, e_data);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; strobe = 1'b0; eoc = 1'b0;
        repeat (3) @(negedge clk);
        chk(conv_n === 1'b1 && cs_n === 1'b1, "R1", "start/cs in reset", {conv_n, cs_n}, 2'b11);
        chk({sclk, valid, ovr, err} === 4'b0, "R1", "flags in reset", {sclk, valid, ovr, err}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(conv_n === 1'b1 && cs_n === 1'b1 && {sclk, valid, ovr, err} === 4'b0,
            "R1", "first cycle after reset", {conv_n, cs_n, sclk, valid, ovr, err}, 6'b110000);
        armed = 1;
    endtask

    task automatic pulse_strobe();
        @(negedge clk) strobe = 1'b1;
        @(negedge clk) strobe = 1'b0;
    endtask

    task automatic pulse_eoc(input int width);
        @(negedge clk) eoc = 1'b1;
        repeat (width) @(negedge clk);
        eoc = 1'b0;
    endtask

    task automatic wait_valid();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (valid) return;
        end
        chk(1'b0, "R5", "valid never seen", 0, 1);
    endtask

    task automatic conversion(input logic [W-1:0] word, input int delay, input int ew);
        slave_word = word;
        pulse_strobe();
        repeat (SL + delay) @(negedge clk);
        pulse_eoc(ew);
        wait_valid();
    endtask

    initial begin
        fork
            begin
                do_reset();
                // R4 R5: alternating word, near-minimum conversion time
                conversion(14'h2A55, 260, 4);
                repeat (QC + 4) @(negedge clk);
                // R3: long conversion, all ones, one-cycle EOC pulse
                conversion(14'h3FFF, 600, 1);
                repeat (QC + 4) @(negedge clk);
                // R4: single low bit, MSB-first ordering
                conversion(14'h1FFF, 300, 3);
                repeat (QC + 4) @(negedge clk);
                chk(ovr == 1'b0, "R6", "no overrun after spaced strobes", ovr, 0);

                // R6: strobe during conversion wait
                slave_word = 14'h0001;
                pulse_strobe();
                repeat (SL + 50) @(negedge clk);
                pulse_strobe();
                @(negedge clk);
                chk(ovr == 1'b1, "R6", "overrun after early strobe", ovr, 1);
                repeat (200) @(negedge clk);
                pulse_eoc(4);
                wait_valid();
                repeat (QC + 4) @(negedge clk);

                // R8: strobe inside hold-off after valid
                do_reset();
                conversion(14'h1234, 280, 4);
                pulse_strobe();
                @(negedge clk);
                chk(ovr == 1'b1, "R8", "overrun in hold-off", ovr, 1);
                chk(conv_n == 1'b1, "R8", "no start in hold-off", conv_n, 1);
                repeat (QC + 4) @(negedge clk);
                conversion(14'h0ABC, 280, 4);
                repeat (QC + 4) @(negedge clk);

                // R7: timeout, then recovery; R9 sticky error
                do_reset();
                pulse_strobe();
                repeat (SL + TO + 10) @(negedge clk);
                chk(err == 1'b1, "R7", "error after missing eoc", err, 1);
                chk(cs_n == 1'b1, "R7", "no readout after timeout", cs_n, 1);
                conversion(14'h2DB6, 300, 4);
                repeat (QC + 4) @(negedge clk);
                chk(err == 1'b1, "R9", "error stays set", err, 1);
                chk(result == 14'h2DB6, "R7", "conversion after timeout", result, 14'h2DB6);
            end
            begin
                repeat (150000) @(posedge clk);
                chk(1'b0, "R1", "watchdog expired", 0, 1);
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule